// File: doc/BRIEF.md
# Masked Multi-Source Interrupt Status Collector

This block gathers single-cycle event pulses from nine audio streaming channels (six playback, three capture) and from the codec register access path. It holds them in a sticky status register that the host reads, and it drives one interrupt line. Each channel reports three events: its FIFO reached the fill threshold, its FIFO underran, and its FIFO overran. The codec access path reports two events: a register write finished and a register read finished.

The host uses a simple 32-bit register port with an access strobe, a write flag, a byte offset and write data. Read data is registered and appears one cycle after the read strobe. A mask register selects which status bits may raise the interrupt. The mask has no effect on what the status register reads back. Reading the status register returns every pending bit and clears them. An event that arrives in the same cycle as that read is kept for the next read.

Top module: `irq_collector`

## Requirements
- R1: After reset, the status register, the mask register and the read data are all zero, and `irq` is low.
- R2: Status bit 0 is set by `cdc_wr_done` and bit 1 by `cdc_rd_done`. Playback channel c (0..5) owns bits 2+3c .. 4+3c. Capture channel k (0..2) owns bits 20+3k .. 22+3k. Within each 3-bit field the lowest bit is the threshold event, the middle bit is underrun and the top bit is overrun. The event ports carry channel c in bits [3c+2:3c] with the same field order.
- R3: A status bit stays set after its event pulse ends, and events in different cycles accumulate, until the host reads the status register.
- R4: A read at byte offset 0x18 returns the status (zero-extended) on `host_rdata` in the next cycle and clears every bit it returned.
- R5: An event pulse in the same cycle as a status read is absent from that read's data and stays set for the following read.
- R6: A write at byte offset 0x14 loads the mask from `host_wdata[28:0]`. A read at 0x14 returns the mask. Bits 31:29 of every read return zero.
- R7: `irq` is high exactly while some status bit and the same mask bit are both set. A mask of 3 lets both codec completion bits raise it.
- R8: The mask does not change the status read data. Masked-off bits still read back as set.
- R9: Writes to offset 0x18 or to any offset other than 0x14 change nothing. Reads of offsets other than 0x14 and 0x18 return zero and clear nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| play_evt | input | 18 | Playback channel event pulses, 3 per channel |
| cap_evt | input | 9 | Capture channel event pulses, 3 per channel |
| cdc_wr_done | input | 1 | Codec register write completed (pulse) |
| cdc_rd_done | input | 1 | Codec register read completed (pulse) |
| host_en | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 8 | Byte offset of the access |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid the cycle after a read |
| irq | output | 1 | Interrupt, high while any unmasked status bit is set |

## Verification
The two functions that can fall in the same cycle are latching a new event and the clear-on-read of the status register. The bench provokes this by raising a capture event pulse in the very cycle that carries the status read strobe, with an older event already pending. It judges the outcome in two steps: the read data must show only the older bit, and a second read must then show the new bit alone. This proves that the clear removed only what was returned.

// File: rtl/irq_pkg.sv
package irq_pkg;
    // host access byte offsets
    localparam int MASK_OFS = 'h14;
    localparam int STAT_OFS = 'h18;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_MASK_WR,
        ACC_MASK_RD,
        ACC_STAT_RD,
        ACC_OTHER_RD,
        ACC_IGNORED_WR
    } acc_kind_e;
endpackage

// File: rtl/irq_acc_decode.sv
module irq_acc_decode #(
    parameter int ADDR_W = 8
) (
    input  logic              en,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output irq_pkg::acc_kind_e kind
);
    import irq_pkg::*;

    logic hit_mask;
    logic hit_stat;

    always_comb begin
        hit_mask = (addr == ADDR_W'(MASK_OFS));
        hit_stat = (addr == ADDR_W'(STAT_OFS));
        if (!en)
            kind = ACC_NONE;
        else if (wr)
            kind = hit_mask ? ACC_MASK_WR : ACC_IGNORED_WR;
        else if (hit_stat)
            kind = ACC_STAT_RD;
        else if (hit_mask)
            kind = ACC_MASK_RD;
        else
            kind = ACC_OTHER_RD;
    end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int W = 29
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         clr,
    output logic [W-1:0] status
);
    typedef struct packed {
        logic [W-1:0] bits;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (clr)
            bank_d.bits = '0;
        // a pulse in the clearing cycle survives the clear
        bank_d.bits = bank_d.bits | evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            bank_q <= '0;
        else
            bank_q <= bank_d;
    end

    assign status = bank_q.bits;
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
    parameter int W = 29
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] value,
    output logic [W-1:0] mask
);
    typedef struct packed {
        logic [W-1:0] bits;
    } mreg_t;

    mreg_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (load)
            m_d.bits = value;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            m_q <= '0;
        else
            m_q <= m_d;
    end

    assign mask = m_q.bits;
endmodule

// File: rtl/irq_collector.sv
module irq_collector #(
    parameter int N_PLAY  = 6,
    parameter int N_CAP   = 3,
    parameter int FLD_W   = 3,
    parameter int CDC_W   = 2,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_PLAY*FLD_W-1:0] play_evt,
    input  logic [N_CAP*FLD_W-1:0]  cap_evt,
    input  logic                    cdc_wr_done,
    input  logic                    cdc_rd_done,
    input  logic                    host_en,
    input  logic                    host_wr,
    input  logic [ADDR_W-1:0]       host_addr,
    input  logic [DATA_W-1:0]       host_wdata,
    output logic [DATA_W-1:0]       host_rdata,
    output logic                    irq
);
    import irq_pkg::*;

    localparam int PLAY_BASE = CDC_W;
    localparam int CAP_BASE  = PLAY_BASE + N_PLAY * FLD_W;
    localparam int STAT_W    = CAP_BASE + N_CAP * FLD_W;
    localparam int PAD_W     = DATA_W - STAT_W;

    logic [STAT_W-1:0] evt_vec;
    logic [STAT_W-1:0] stat_w;
    logic [STAT_W-1:0] mask_w;
    acc_kind_e         kind;

    // pack event pulses into their status positions
    assign evt_vec[0] = cdc_wr_done;
    assign evt_vec[1] = cdc_rd_done;

    for (genvar c = 0; c < N_PLAY; c++) begin : g_play
        assign evt_vec[PLAY_BASE + c*FLD_W +: FLD_W] = play_evt[c*FLD_W +: FLD_W];
    end

    for (genvar k = 0; k < N_CAP; k++) begin : g_cap
        assign evt_vec[CAP_BASE + k*FLD_W +: FLD_W] = cap_evt[k*FLD_W +: FLD_W];
    end

    irq_acc_decode #(.ADDR_W(ADDR_W)) u_dec (
        .en   (host_en),
        .wr   (host_wr),
        .addr (host_addr),
        .kind (kind)
    );

    irq_status_bank #(.W(STAT_W)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt_vec),
        .clr    (kind == ACC_STAT_RD),
        .status (stat_w)
    );

    irq_mask_bank #(.W(STAT_W)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (kind == ACC_MASK_WR),
        .value (host_wdata[STAT_W-1:0]),
        .mask  (mask_w)
    );

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              irq;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d = out_q;
        unique case (kind)
            ACC_STAT_RD:  out_d.rdata = {{PAD_W{1'b0}}, stat_w};
            ACC_MASK_RD:  out_d.rdata = {{PAD_W{1'b0}}, mask_w};
            ACC_OTHER_RD: out_d.rdata = '0;
            default:      out_d.rdata = out_q.rdata;
        endcase
        out_d.irq = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= '0;
        else
            out_q <= out_d;
    end

    assign host_rdata = out_q.rdata;
    // interrupt follows the registered status and mask directly
    assign irq = |(stat_w & mask_w);
endmodule

// File: rtl/irq_collector_chk.sv
module irq_collector_chk #(
    parameter int W      = 29,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [W-1:0]      evt,
    input logic [W-1:0]      status,
    input logic              host_en,
    input logic              host_wr,
    input logic [ADDR_W-1:0] host_addr,
    input logic [DATA_W-1:0] host_wdata,
    input logic [DATA_W-1:0] host_rdata,
    input logic              irq
);
    import irq_pkg::*;

    logic stat_rd;
    logic mask_clr_wr;

    assign stat_rd     = host_en && !host_wr && (host_addr == ADDR_W'(STAT_OFS));
    assign mask_clr_wr = host_en && host_wr && (host_addr == ADDR_W'(MASK_OFS))
                         && (host_wdata[W-1:0] == '0);

    // R2
    evt_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((status & $past(evt)) == $past(evt)));

    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> ((status & $past(status)) == $past(status)));

    // R4
    read_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> (host_rdata == DATA_W'($past(status))));

    // R4
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && evt == '0) |=> (status == '0));

    // R6
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdata[DATA_W-1:W] == '0);

    // R7
    mask_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_clr_wr |=> !irq);
endmodule

bind irq_collector irq_collector_chk #(
    .W      (STAT_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt        (evt_vec),
    .status     (stat_w),
    .host_en    (host_en),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .irq        (irq)
);

// File: tb/irq_collector_bench.sv
module irq_collector_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] play_evt = '0;
    logic [8:0]  cap_evt = '0;
    logic        cdc_wr_done = 1'b0;
    logic        cdc_rd_done = 1'b0;
    logic        host_en = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    irq_collector u_irq_collector (
        .clk(clk), .rst_n(rst_n), .play_evt(play_evt), .cap_evt(cap_evt),
        .cdc_wr_done(cdc_wr_done), .cdc_rd_done(cdc_rd_done),
        .host_en(host_en), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
    );

    localparam int NV = 6;
    // event pattern (status bit positions), mask, expected irq
    localparam logic [28:0] V_EVT [NV] = '{29'h1, 29'h2, 29'h4, 29'h80000, 29'h200000, 29'h10000000};
    localparam logic [28:0] V_MSK [NV] = '{29'h3, 29'h0, 29'h4, 29'h4, 29'h1FFFFFFF, 29'h10000000};
    localparam logic        V_IRQ [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};

    task automatic chk32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive pulses at status positions for one cycle (mapping per R2)
    task automatic set_evt(input logic [28:0] e);
        cdc_wr_done = e[0];
        cdc_rd_done = e[1];
        play_evt    = e[19:2];
        cap_evt     = e[28:20];
    endtask

    task automatic pulse(input logic [28:0] e);
        @(negedge clk); set_evt(e);
        @(negedge clk); set_evt('0);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        host_en = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_en = 1'b0; host_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        host_en = 1'b1; host_wr = 1'b0; host_addr = a;
        @(negedge clk);
        host_en = 1'b0;
        d = host_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk32("R1 rdata", host_rdata, 32'h0);
        chk32("R1 irq", {31'b0, irq}, 32'h0);
        rd_reg(8'h18, r); chk32("R1 status", r, 32'h0);
        rd_reg(8'h14, r); chk32("R1 mask", r, 32'h0);

        // table walk: R2 R4 R6 R7
        for (int i = 0; i < NV; i++) begin
            wr_reg(8'h14, {3'b111, V_MSK[i]});
            rd_reg(8'h14, r); chk32("R6 mask readback", r, {3'b000, V_MSK[i]});
            pulse(V_EVT[i]);
            chk32("R7 irq", {31'b0, irq}, {31'b0, V_IRQ[i]});
            rd_reg(8'h18, r); chk32("R2 R4 status", r, {3'b000, V_EVT[i]});
            chk32("R4 irq after clear", {31'b0, irq}, 32'h0);
            rd_reg(8'h18, r); chk32("R4 cleared", r, 32'h0);
        end

        // R3 accumulation across cycles
        wr_reg(8'h14, 32'h0);
        pulse(29'h8);        // play ch0 underrun
        repeat (3) @(negedge clk);
        pulse(29'h400);      // play ch2 overrun (bit 10)
        rd_reg(8'h18, r); chk32("R3 sticky accumulate", r, 32'h408);

        // R8 mask does not hide status, irq stays low
        pulse(29'h20);
        chk32("R8 irq masked", {31'b0, irq}, 32'h0);
        rd_reg(8'h18, r); chk32("R8 masked bit readback", r, 32'h20);

        // R5 event coincident with status read
        pulse(29'h1);
        @(negedge clk);
        host_en = 1'b1; host_wr = 1'b0; host_addr = 8'h18;
        set_evt(29'h800000);  // capture ch1 threshold (bit 23)
        @(negedge clk);
        host_en = 1'b0; set_evt('0);
        chk32("R5 read excludes new event", host_rdata, 32'h1);
        rd_reg(8'h18, r); chk32("R5 new event kept", r, 32'h800000);

        // R9 ignored writes and other offsets
        wr_reg(8'h14, 32'h1FFFFFFF);
        wr_reg(8'h18, 32'hFFFFFFFF);
        chk32("R9 status write no irq", {31'b0, irq}, 32'h0);
        rd_reg(8'h18, r); chk32("R9 status unchanged", r, 32'h0);
        wr_reg(8'h10, 32'h0);
        rd_reg(8'h14, r); chk32("R9 other write keeps mask", r, 32'h1FFFFFFF);
        pulse(29'h4000);
        rd_reg(8'h1C, r); chk32("R9 other read zero", r, 32'h0);
        chk32("R9 other read no clear", {31'b0, irq}, 32'h1);
        rd_reg(8'h18, r); chk32("R9 status survives", r, 32'h4000);

        // R7 codec completion bits with mask 3
        wr_reg(8'h14, 32'h3);
        pulse(29'h2);
        chk32("R7 mask3 read done", {31'b0, irq}, 32'h1);
        rd_reg(8'h18, r);

        // R1 reset clears pending state
        pulse(29'h1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk32("R1 irq after reset", {31'b0, irq}, 32'h0);
        rd_reg(8'h14, r); chk32("R1 mask after reset", r, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule